// File: doc/BRIEF.md
# Privileged Control Register File

This block holds the internal control registers that privileged handler code reads and writes by index. It has one combinational read port and one write port that updates on the clock edge. Every index has its own write rule: a plain 64-bit store, a bit mask, a cleared bit, or a clear on any write. A few indices can only be read, a few can only be written, and the rest of the index space is undefined. A speculation input suppresses every write. The cycle-count index returns its stored upper half joined with the low half of a live count that comes in on a port.

Reset loads a fixed handler base, a small control constant and the CPU identifier into three registers, and clears all others. An illegal access gives a one-cycle error pulse: reading a write-only or undefined index, or writing a read-only or undefined index.

Top module: `ipr_file`

## Requirements
- R1: While `rst_n` is low at a clock edge, all 32 registers become zero, with three exceptions: index 8 takes `HBASE_RST` (default 0x10000), index 9 takes 6, and index 7 takes `cpu_id` zero-extended. `err` is 0 after reset.
- R2: Indices 0 to 9 keep all 64 written bits.
- R3: A write to index 10 stores the data with bit 1 forced to 0.
- R4: Indices 11 and 12 keep only bits 3:0. Index 13 keeps only bits 4:0. Indices 14 and 15 keep only bits 4:3.
- R5: These indices keep only the bits of their mask: index 16 uses 0x7fff0, index 17 uses 0xffffff0300, index 18 uses bits 63:30, index 19 uses 0x1ffb, and indices 20 and 21 use bits 5:0.
- R6: Any write to index 22 or index 23 sets it to zero.
- R7: Index 24 keeps all 64 written bits. A read of it returns stored bits 63:32 joined with `cyc_cnt[31:0]` as the low half.
- R8: Indices 25 and 26 are read-only. A write leaves them unchanged and raises `err`. A read returns the stored value, which is zero after reset.
- R9: Indices 27 and 28 are write-only. A write is accepted without error. A read returns 0 and raises `err`.
- R10: Indices 29 to 31 are undefined. A read returns 0. Both a read and a write raise `err`.
- R11: While `spec` is 1, a write changes no register and raises no error.
- R12: `rd_data` follows `rd_idx` in the same cycle. A write becomes visible after the next clock edge. `err` is high for exactly the one cycle after the edge that sampled the illegal access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_id | input | ID_W | CPU identifier loaded into index 7 at reset |
| cyc_cnt | input | 64 | Free-running cycle count |
| spec | input | 1 | Speculation: suppresses writes |
| rd_en | input | 1 | Read request |
| rd_idx | input | 5 | Read index |
| rd_data | output | 64 | Read data, combinational |
| wr_en | input | 1 | Write request |
| wr_idx | input | 5 | Write index |
| wr_data | input | 64 | Write data |
| err | output | 1 | Illegal-access pulse |

## Verification
Every one of the 32 indices is written with all-ones, with two alternating checkerboards and with zero, then read back. All-ones exposes which bits each mask keeps. The two checkerboards tell a wrong mask from a bit that is merely stuck. Zero shows that masked bits really clear. During each legal write, the same index is read in the same cycle to tell the old value from the new one. An all-ones sweep under `spec` shows that nothing changes and no error is raised. Because the cycle index is read while the live count moves, a stale or missing merge shows up as a wrong low half.

// File: rtl/ipr_pkg.sv
// Package: index map, access kinds and per-index write masks of the
// privileged control register file. Assumes a 5-bit index space.
package ipr_pkg;
    localparam int DATA_W = 64;
    localparam int IDX_W  = 5;
    localparam int NREG   = 1 << IDX_W;

    localparam logic [IDX_W-1:0] IX_CPUSLOT  = 5'd7;
    localparam logic [IDX_W-1:0] IX_HBASE    = 5'd8;
    localparam logic [IDX_W-1:0] IX_MISC     = 5'd9;
    localparam logic [IDX_W-1:0] IX_EXC_RET  = 5'd10;
    localparam logic [IDX_W-1:0] IX_PRIO     = 5'd13;
    localparam logic [IDX_W-1:0] IX_EXC_SUM  = 5'd22;
    localparam logic [IDX_W-1:0] IX_CYC      = 5'd24;
    localparam logic [IDX_W-1:0] IX_INTID    = 5'd25;

    typedef enum logic [1:0] {K_PLAIN, K_RO, K_WO, K_NONE} kind_e;

    // Access kind of an index.
    function automatic kind_e kind_of(input logic [IDX_W-1:0] ix);
        if (ix <= 5'd24)                    return K_PLAIN;
        else if (ix == 5'd25 || ix == 5'd26) return K_RO;
        else if (ix == 5'd27 || ix == 5'd28) return K_WO;
        else                                 return K_NONE;
    endfunction

    // Bits a write keeps; zero mask means clear-on-write.
    function automatic logic [DATA_W-1:0] mask_of(input logic [IDX_W-1:0] ix);
        case (ix)
            5'd10:        return ~64'h2;
            5'd11, 5'd12: return 64'hf;
            5'd13:        return 64'h1f;
            5'd14, 5'd15: return 64'h18;
            5'd16:        return 64'h7fff0;
            5'd17:        return 64'hff_ffff_0300;
            5'd18:        return 64'hffff_ffff_c000_0000;
            5'd19:        return 64'h1ffb;
            5'd20, 5'd21: return 64'h3f;
            5'd22, 5'd23: return 64'h0;
            default:      return {DATA_W{1'b1}};
        endcase
    endfunction
endpackage

// File: rtl/ipr_decode.sv
// Access decoder: classifies the read and write indices, shapes the write
// data with the per-index mask and flags illegal accesses.
// Assumes the read and write ports are independent in a cycle.
module ipr_decode
    import ipr_pkg::*;
(
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              wr_en,
    input  logic              spec,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_fire,
    output logic [DATA_W-1:0] wr_val,
    output logic              rd_ok,
    output logic              bad_access
);
    kind_e rk, wk;

    // Classify both ports and build write enable and masked data.
    always_comb begin
        rk         = kind_of(rd_idx);
        wk         = kind_of(wr_idx);
        rd_ok      = (rk == K_PLAIN) || (rk == K_RO);
        wr_fire    = wr_en && !spec && ((wk == K_PLAIN) || (wk == K_WO));
        wr_val     = wr_data & mask_of(wr_idx);
        bad_access = (rd_en && !rd_ok)
                   || (wr_en && !spec && ((wk == K_RO) || (wk == K_NONE)));
    end
endmodule

// File: rtl/ipr_store.sv
// Register storage: one 64-bit register per index with its reset value.
// Assumes the write data is already masked and the enable already legal.
module ipr_store
    import ipr_pkg::*;
#(
    parameter int              ID_W      = 8,
    parameter logic [DATA_W-1:0] HBASE_RST = 64'h0000_0000_0001_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   cpu_id,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] regs_q [NREG]
);
    logic [DATA_W-1:0] init_v [NREG];

    // Reset value of each slot.
    for (genvar g = 0; g < NREG; g++) begin : g_init
        if (g == int'(IX_HBASE)) begin : g_hb
            assign init_v[g] = HBASE_RST;
        end else if (g == int'(IX_MISC)) begin : g_misc
            assign init_v[g] = 64'd6;
        end else if (g == int'(IX_CPUSLOT)) begin : g_id
            assign init_v[g] = DATA_W'(cpu_id);
        end else begin : g_zero
            assign init_v[g] = '0;
        end
    end

    // Load reset values or store the addressed write.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (!rst_n)
                regs_q[i] <= init_v[i];
            else if (we && widx == IDX_W'(i))
                regs_q[i] <= wdata;
        end
    end

    a_r3_exc_ret_bit1: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q[IX_EXC_RET][1] == 1'b0);
    a_r4_prio_width: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q[IX_PRIO][DATA_W-1:5] == '0);
endmodule

// File: rtl/ipr_readmux.sv
// Read path: selects the addressed register and joins the live low half
// of the cycle count for the cycle index. Illegal reads return zero.
module ipr_readmux
    import ipr_pkg::*;
(
    input  logic              rd_en,
    input  logic              rd_ok,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [DATA_W-1:0] cyc_cnt,
    input  logic [DATA_W-1:0] regs_q [NREG],
    output logic [DATA_W-1:0] rd_data
);
    localparam int HALF = DATA_W / 2;

    // Select and merge read data.
    always_comb begin
        rd_data = '0;
        if (rd_en && rd_ok) begin
            if (rd_idx == IX_CYC)
                rd_data = {regs_q[rd_idx][DATA_W-1:HALF], cyc_cnt[HALF-1:0]};
            else
                rd_data = regs_q[rd_idx];
        end
    end
endmodule

// File: rtl/ipr_file.sv
// Top: privileged control register file with per-index write rules,
// suppressed writes under speculation and a registered error pulse.
// Assumes a synchronous active-low reset.
module ipr_file
    import ipr_pkg::*;
#(
    parameter int                ID_W      = 8,
    parameter logic [DATA_W-1:0] HBASE_RST = 64'h0000_0000_0001_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   cpu_id,
    input  logic [DATA_W-1:0] cyc_cnt,
    input  logic              spec,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic              err
);
    logic              wr_fire, rd_ok, bad_access;
    logic [DATA_W-1:0] wr_val;
    logic [DATA_W-1:0] regs_q [NREG];

    ipr_decode u_dec (
        .rd_en(rd_en), .rd_idx(rd_idx), .wr_en(wr_en), .spec(spec),
        .wr_idx(wr_idx), .wr_data(wr_data), .wr_fire(wr_fire),
        .wr_val(wr_val), .rd_ok(rd_ok), .bad_access(bad_access)
    );

    ipr_store #(.ID_W(ID_W), .HBASE_RST(HBASE_RST)) u_store (
        .clk(clk), .rst_n(rst_n), .cpu_id(cpu_id), .we(wr_fire),
        .widx(wr_idx), .wdata(wr_val), .regs_q(regs_q)
    );

    ipr_readmux u_rd (
        .rd_en(rd_en), .rd_ok(rd_ok), .rd_idx(rd_idx), .cyc_cnt(cyc_cnt),
        .regs_q(regs_q), .rd_data(rd_data)
    );

    // Register the illegal-access flag into a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) err <= 1'b0;
        else        err <= bad_access;
    end

    a_r6_clear_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !spec && wr_idx == IX_EXC_SUM) |=> regs_q[IX_EXC_SUM] == '0);
    a_r7_cycle_low: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_idx == IX_CYC) |-> rd_data[31:0] == cyc_cnt[31:0]);
    a_r8_ro_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IX_INTID) |=> $stable(regs_q[IX_INTID]));
    a_r9_wo_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && kind_of(rd_idx) == K_WO) |-> rd_data == '0);
    a_r11_spec_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && spec && wr_idx == IX_HBASE) |=> $stable(regs_q[IX_HBASE]));
endmodule

// File: tb/ipr_file_test.sv
`timescale 1ns/100ps
module ipr_file_test;
    localparam logic [63:0] HB  = 64'h0000_0000_0001_0000;
    localparam logic [7:0]  CID = 8'h5C;

    logic        clk = 0, rst_n = 0, spec = 0, rd_en = 0, wr_en = 0;
    logic [4:0]  rd_idx = 0, wr_idx = 0;
    logic [63:0] wr_data = 0, rd_data;
    logic [63:0] cyc = 64'hFFFF_FFF0_1234_5670;
    logic [7:0]  cpu_id = CID;
    logic        err;
    int          checks = 0, errors = 0;
    logic [63:0] sh [32];
    logic [63:0] pats [4];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 64'h0000_0001_0000_0003;

    ipr_file #(.ID_W(8), .HBASE_RST(HB)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_id(cpu_id), .cyc_cnt(cyc), .spec(spec),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .err(err)
    );

    function automatic logic [63:0] bmask(int i);
        case (i)
            10:     return ~64'h2;
            11, 12: return 64'hf;
            13:     return 64'h1f;
            14, 15: return 64'h18;
            16:     return 64'h7fff0;
            17:     return 64'hff_ffff_0300;
            18:     return 64'hffff_ffff_c000_0000;
            19:     return 64'h1ffb;
            20, 21: return 64'h3f;
            22, 23: return 64'h0;
            default: return '1;
        endcase
    endfunction

    function automatic bit is_ro(int i);   return i == 25 || i == 26; endfunction
    function automatic bit is_wo(int i);   return i == 27 || i == 28; endfunction
    function automatic bit is_none(int i); return i >= 29;            endfunction

    function automatic string req_of(int i);
        if (i == 10)      return "R3";
        if (i >= 11 && i <= 15) return "R4";
        if (i >= 16 && i <= 21) return "R5";
        if (i == 22 || i == 23) return "R6";
        if (i == 24)      return "R7";
        if (is_ro(i))     return "R8";
        if (is_wo(i))     return "R9";
        if (is_none(i))   return "R10";
        return "R2";
    endfunction

    function automatic logic [63:0] exp_rd(int i);
        if (is_wo(i) || is_none(i)) return 64'h0;
        if (i == 24) return {sh[24][63:32], cyc[31:0]};
        return sh[i];
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Read one index: data in the same cycle, error after the edge.
    task automatic rd_check(int i, string req);
        @(negedge clk);
        wr_en = 0; rd_en = 1; rd_idx = 5'(i);
        #0.5;
        check(req, rd_data, exp_rd(i));
        @(negedge clk);
        check({req, " err"}, 64'(err), 64'(is_wo(i) || is_none(i)));
        rd_en = 0;
    endtask

    // Write one index; legal ones are read back before and after the edge (R12).
    task automatic wr_op(int i, logic [63:0] p);
        bit rw;
        rw = (i <= 24);
        @(negedge clk);
        wr_en = 1; wr_idx = 5'(i); wr_data = p; rd_en = rw; rd_idx = 5'(i);
        #0.5;
        if (rw) check("R12 old value", rd_data, exp_rd(i));
        if (!spec) begin
            if (i <= 24)     sh[i] = p & bmask(i);
            else if (is_wo(i)) sh[i] = p;
        end
        @(negedge clk);
        if (rw) check({req_of(i), " R12 new value"}, rd_data, exp_rd(i));
        check(spec ? "R11 err" : {req_of(i), " err"}, 64'(err),
              64'(!spec && (is_ro(i) || is_none(i))));
        wr_en = 0; rd_en = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        pats[0] = '1;
        pats[1] = 64'hA5A5_A5A5_A5A5_A5A5;
        pats[2] = 64'h5A5A_5A5A_5A5A_5A5A;
        pats[3] = '0;
        for (int i = 0; i < 32; i++) sh[i] = '0;
        sh[8] = HB; sh[9] = 64'd6; sh[7] = 64'(CID);

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        check("R1 err", 64'(err), 64'h0);
        for (int i = 0; i < 32; i++) rd_check(i, "R1");

        for (int k = 0; k < 4; k++)
            for (int i = 0; i < 32; i++) begin
                wr_op(i, pats[k]);
                rd_check(i, req_of(i));
            end

        // Non-zero content first, so a suppressed write is visible (R11).
        for (int i = 0; i < 25; i++) wr_op(i, 64'h0123_4567_89AB_CDEF);
        spec = 1;
        for (int i = 0; i < 32; i++) wr_op(i, '1);
        spec = 0;
        for (int i = 0; i < 32; i++) rd_check(i, "R11");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule